// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked host and an external 32K x 16 static RAM that has no clock of its own. The host hands over one word request at a time: a 15-bit word address, a read/write flag, 16 bits of write data and a two-bit lane mask. The controller then drives the memory's active-low chip, output, write and lane strobes. Each phase of the access is held for a whole number of system clock cycles. That count comes from nanosecond minimum times given as parameters.

Writes are timed by the write strobe. The controller drives the shared data bus only during a write, and never while the memory's output enable is low. After every read it waits out the memory's output-disable time before it takes another request, so the two sides never drive the bus at once. Read data is sampled in the last cycle of the access window. Any lane the host did not select comes back as zero.

The request side follows valid/ready rules. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle, and the host must hold its request fields steady until that edge. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse that the host must take when it appears.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During and after reset, until the first request is taken, all memory strobes (`mem_ce_n`, `mem_oe_n`, `mem_we_n`, both bits of `mem_be_n`) are high, `mem_dq_oe` is low, `req_ready` is high and `rsp_valid` is low.
- R2: A request is taken only in the idle state (`req_ready` high). Each request taken produces exactly one single-cycle `rsp_valid` pulse, in request order, and `rsp_valid` is only ever high while `req_ready` is high.
- R3: A write with a nonzero mask holds `mem_ce_n` and `mem_we_n` low for N_WP consecutive cycles, with `mem_oe_n` high. N_WP is the largest of ceil(T_WP/CLK), ceil(T_DS/CLK) and ceil(T_CW/CLK), and is at least 1. In `mem_be_n`, bit 0 is the lower lane (data bits 7..0) and bit 1 is the upper lane (bits 15..8). Each bit is low exactly when the matching mask bit is 1.
- R4: After `mem_we_n` rises, `mem_ce_n`, the lanes and `mem_dq_oe` stay asserted for N_WH cycles, where N_WH = max(1, ceil(T_WC/CLK) - N_WP). Then `mem_dq_oe` drops and the write is acknowledged.
- R5: `mem_dq_oe` is high only during a write, and never while `mem_oe_n` is low.
- R6: A read with a nonzero mask holds `mem_ce_n` and `mem_oe_n` low with `mem_we_n` high for N_RD consecutive cycles, where N_RD = max(ceil(T_AA/CLK), ceil(T_OE/CLK)). `mem_dq_in` is captured on the last of those cycles.
- R7: In `rsp_rdata`, the bits of a lane whose mask bit is 0 read as zero.
- R8: After a read, all strobes stay high for N_TURN = ceil(T_OHZ/CLK) cycles before the controller returns to idle. No new access starts earlier than N_TURN+1 cycles after `mem_oe_n` rises.
- R9: A request with mask 00 asserts no memory strobe. It is acknowledged on the cycle right after it is taken, and a read of this kind leaves `rsp_rdata` unchanged.
- R10: `mem_addr` is stable for as long as `mem_ce_n` stays low.
- R11: A one-lane write leaves the other lane of the stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 0 = low byte |
| rsp_valid | output | 1 | One-cycle acknowledge |
| rsp_rdata | output | 16 | Read data, valid with acknowledge |
| mem_addr | output | 15 | Memory address pins |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | 2 | Lane enables, active low, bit 0 = low byte |
| mem_dq_out | output | 16 | Data driven onto the bus |
| mem_dq_oe | output | 1 | Controller drives the data bus |
| mem_dq_in | input | 16 | Data seen on the bus |

## Verification
A wrong state or a miscounted interval shows up at the memory pins within the access itself. A strobe window ends up one cycle too short or too long. The write enable and output enable can overlap with the bus drive. Or the idle gap after a read is shorter than the turnaround count. The bench measures each of these windows against counts it works out from the timing parameters.

A stale lane mask or a capture taken in the wrong cycle shows up at the response port. The data comes back wrong on the acknowledge of the next read of that word. A lost or duplicated acknowledge shows up when the pulses are matched against the queue of requests issued.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_WR_PULSE = 3'd1,
    ST_WR_HOLD  = 3'd2,
    ST_RD_ACC   = 3'd3,
    ST_RD_TURN  = 3'd4
  } seq_state_t;

  // Whole clock cycles covering a minimum time, never fewer than one.
  function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_lane_pkg::*;
#(
  parameter int unsigned AW     = 15,
  parameter int unsigned DW     = 16,
  parameter int unsigned LANES  = 2,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned N_WP   = 1,
  parameter int unsigned N_WH   = 1,
  parameter int unsigned N_RD   = 1,
  parameter int unsigned N_TURN = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [LANES-1:0] req_mask,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output seq_state_t       state,
  output logic [AW-1:0]    lat_addr,
  output logic [DW-1:0]    lat_wdata,
  output logic [LANES-1:0] lat_mask,
  output logic             capture,
  output logic             rsp_valid
);
  localparam logic [CNT_W-1:0] LD_WP   = CNT_W'(N_WP - 1);
  localparam logic [CNT_W-1:0] LD_WH   = CNT_W'(N_WH - 1);
  localparam logic [CNT_W-1:0] LD_RD   = CNT_W'(N_RD - 1);
  localparam logic [CNT_W-1:0] LD_TURN = CNT_W'(N_TURN - 1);

  seq_state_t state_nxt;
  logic       take, take_real, ack_nxt;

  assign req_ready = (state == ST_IDLE);
  assign take      = req_ready && req_valid;
  assign take_real = take && (req_mask != '0);
  assign capture   = (state == ST_RD_ACC) && tmr_expired;

  always_comb begin
    state_nxt = state;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    ack_nxt   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (take && !take_real) begin
          ack_nxt = 1'b1;
        end else if (take_real) begin
          tmr_load  = 1'b1;
          tmr_val   = req_write ? LD_WP : LD_RD;
          state_nxt = req_write ? ST_WR_PULSE : ST_RD_ACC;
        end
      end
      ST_WR_PULSE: if (tmr_expired) begin
        tmr_load  = 1'b1;
        tmr_val   = LD_WH;
        state_nxt = ST_WR_HOLD;
      end
      ST_WR_HOLD: if (tmr_expired) begin
        ack_nxt   = 1'b1;
        state_nxt = ST_IDLE;
      end
      ST_RD_ACC: if (tmr_expired) begin
        tmr_load  = 1'b1;
        tmr_val   = LD_TURN;
        state_nxt = ST_RD_TURN;
      end
      ST_RD_TURN: if (tmr_expired) begin
        ack_nxt   = 1'b1;
        state_nxt = ST_IDLE;
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      rsp_valid <= 1'b0;
      lat_addr  <= '0;
      lat_wdata <= '0;
      lat_mask  <= '0;
    end else begin
      state     <= state_nxt;
      rsp_valid <= ack_nxt;
      if (take_real) begin
        lat_addr  <= req_addr;
        lat_wdata <= req_wdata;
        lat_mask  <= req_mask;
      end
    end
  end
endmodule

// File: rtl/sram_pin_drv.sv
module sram_pin_drv
  import sram_lane_pkg::*;
#(
  parameter int unsigned AW    = 15,
  parameter int unsigned DW    = 16,
  parameter int unsigned LANES = 2
) (
  input  seq_state_t       state,
  input  logic [AW-1:0]    lat_addr,
  input  logic [DW-1:0]    lat_wdata,
  input  logic [LANES-1:0] lat_mask,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_ce_n,
  output logic             mem_oe_n,
  output logic             mem_we_n,
  output logic [LANES-1:0] mem_be_n,
  output logic [DW-1:0]    mem_dq_out,
  output logic             mem_dq_oe
);
  logic in_write, in_access;

  assign in_write  = (state == ST_WR_PULSE) || (state == ST_WR_HOLD);
  assign in_access = in_write || (state == ST_RD_ACC);

  assign mem_addr   = lat_addr;
  assign mem_dq_out = lat_wdata;
  assign mem_ce_n   = !in_access;
  assign mem_oe_n   = (state != ST_RD_ACC);
  assign mem_we_n   = (state != ST_WR_PULSE);
  assign mem_dq_oe  = in_write;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign mem_be_n[l] = !(in_access && lat_mask[l]);
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CLK_NS    = 10,
  parameter int unsigned T_WP_NS   = 7,
  parameter int unsigned T_DS_NS   = 6,
  parameter int unsigned T_CW_NS   = 9,
  parameter int unsigned T_WC_NS   = 10,
  parameter int unsigned T_AA_NS   = 10,
  parameter int unsigned T_OE_NS   = 6,
  parameter int unsigned T_OHZ_NS  = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic [DATA_W/8-1:0]    req_mask,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic                   mem_ce_n,
  output logic                   mem_oe_n,
  output logic                   mem_we_n,
  output logic [DATA_W/8-1:0]    mem_be_n,
  output logic [DATA_W-1:0]      mem_dq_out,
  output logic                   mem_dq_oe,
  input  logic [DATA_W-1:0]      mem_dq_in
);
  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned N_WP   = umax(ns_to_cyc(T_WP_NS, CLK_NS),
                                        umax(ns_to_cyc(T_DS_NS, CLK_NS), ns_to_cyc(T_CW_NS, CLK_NS)));
  localparam int unsigned N_WC   = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int unsigned N_WH   = (N_WC > N_WP) ? (N_WC - N_WP) : 1;
  localparam int unsigned N_RD   = umax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS));
  localparam int unsigned N_TURN = ns_to_cyc(T_OHZ_NS, CLK_NS);
  localparam int unsigned N_MAX  = umax(umax(N_WP, N_WH), umax(N_RD, N_TURN));
  localparam int unsigned CNT_W  = $clog2(N_MAX + 1);

  seq_state_t        state;
  logic              tmr_load, tmr_expired, capture;
  logic [CNT_W-1:0]  tmr_val;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;
  logic [LANES-1:0]  lat_mask;

  sram_cyc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
  );

  sram_seq_fsm #(
    .AW(ADDR_W), .DW(DATA_W), .LANES(LANES), .CNT_W(CNT_W),
    .N_WP(N_WP), .N_WH(N_WH), .N_RD(N_RD), .N_TURN(N_TURN)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .tmr_expired(tmr_expired), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .state(state), .lat_addr(lat_addr), .lat_wdata(lat_wdata), .lat_mask(lat_mask),
    .capture(capture), .rsp_valid(rsp_valid)
  );

  sram_pin_drv #(.AW(ADDR_W), .DW(DATA_W), .LANES(LANES)) u_pins (
    .state(state), .lat_addr(lat_addr), .lat_wdata(lat_wdata), .lat_mask(lat_mask),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
  );

  // Read capture per lane; unselected lanes return zero.
  for (genvar l = 0; l < LANES; l++) begin : g_cap
    always_ff @(posedge clk) begin
      if (!rst_n)       rsp_rdata[l*8 +: 8] <= '0;
      else if (capture) rsp_rdata[l*8 +: 8] <= lat_mask[l] ? mem_dq_in[l*8 +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/sram_lane_chk.sv
module sram_lane_chk #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned LANES  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [LANES-1:0]  mem_be_n,
  input logic              mem_dq_oe
);
  // R5
  bus_no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R3
  write_strobe_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

  // R2
  ack_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

  // R10
  addr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && (&mem_be_n) && !mem_dq_oe));

  // R9
  lanes_need_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_be_n != '1) |-> !mem_ce_n);
endmodule

bind sram_lane_ctrl sram_lane_chk #(.ADDR_W(ADDR_W), .LANES(DATA_W/8)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_be_n(mem_be_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;
  localparam int CLK_PERIOD = 10;
  // Design modelled at 4 ns per cycle; expected counts from the requirements:
  // N_WP = max(ceil(7/4),ceil(6/4),ceil(9/4)) = 3, N_WH = max(1, 3-3) = 1,
  // N_RD = max(ceil(10/4),ceil(6/4)) = 3, N_TURN = ceil(6/4) = 2.
  localparam int N_WP = 3, N_WH = 1, N_RD = 3, N_TURN = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_ready, rsp_valid;
  logic [14:0] req_addr = '0, mem_addr;
  logic [15:0] req_wdata = '0, rsp_rdata, mem_dq_out, mem_dq_in;
  logic [1:0]  req_mask = '0, mem_be_n;
  logic mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_lane_ctrl #(.CLK_NS(4)) i_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // Memory model: index by low address bits, write on rising write strobe.
  logic [15:0] marr [0:1023];
  always @(posedge mem_we_n) begin
    if (mem_ce_n === 1'b0 && mem_dq_oe === 1'b1) begin
      if (!mem_be_n[0]) marr[mem_addr[9:0]][7:0]  <= mem_dq_out[7:0];
      if (!mem_be_n[1]) marr[mem_addr[9:0]][15:8] <= mem_dq_out[15:8];
    end
  end
  always_comb begin
    if (mem_ce_n === 1'b0 && mem_oe_n === 1'b0 && mem_we_n === 1'b1)
      mem_dq_in = {mem_be_n[1] ? 8'hA5 : marr[mem_addr[9:0]][15:8],
                   mem_be_n[0] ? 8'h5A : marr[mem_addr[9:0]][7:0]};
    else
      mem_dq_in = 16'hA55A;
  end

  int n_checks = 0, n_fail = 0, n_issued = 0, n_acked = 0;
  logic [15:0] shadow [0:1023];
  logic [15:0] last_rd = 16'h0000;

  typedef struct packed { logic is_rd; logic chk_data; logic [15:0] exp; } item_t;
  item_t       exp_q  [$];
  logic [1:0]  mask_q [$];

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: pushes expectation, presents request, holds until taken.
  task automatic issue(input logic wr, input logic [14:0] a, input logic [15:0] d, input logic [1:0] m);
    item_t it;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    it.is_rd = !wr; it.chk_data = !wr; it.exp = 16'h0;
    if (wr) begin
      if (m[0]) shadow[a[9:0]][7:0]  = d[7:0];
      if (m[1]) shadow[a[9:0]][15:8] = d[15:8];
    end else if (m == 2'b00) begin
      it.exp = last_rd;
    end else begin
      it.exp  = {m[1] ? shadow[a[9:0]][15:8] : 8'h00, m[0] ? shadow[a[9:0]][7:0] : 8'h00};
      last_rd = it.exp;
    end
    exp_q.push_back(it);
    if (m != 2'b00) mask_q.push_back(m);
    n_issued++;
    @(negedge clk);
    req_valid = 1'b0;
    if (m == 2'b00) begin
      // R9: acknowledged on the next cycle, no strobe
      check(rsp_valid === 1'b1 && mem_ce_n === 1'b1 && mem_be_n === 2'b11, "R9 noop ack",
            {rsp_valid, mem_ce_n, mem_be_n}, 4'b1111);
    end
  endtask

  // Monitor: scoreboard and strobe window measurement.
  logic p_we = 1'b1, p_oe = 1'b1, p_ce = 1'b1, p_dqoe = 1'b0, gap_on = 1'b0;
  int we_run = 0, oe_run = 0, hold_run = 0, gap_cnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        item_t it;
        n_acked++;
        if (exp_q.size() == 0) check(1'b0, "R2 unexpected ack", 1, 0);
        else begin
          it = exp_q.pop_front();
          if (it.is_rd) check(rsp_rdata === it.exp, "R6/R7/R11 read data", rsp_rdata, it.exp);
        end
      end
      if (mem_dq_oe && !mem_oe_n) check(1'b0, "R5 bus overlap", 1, 0);
      if (!mem_ce_n && req_ready) check(1'b0, "R2 ready while busy", 1, 0);
      // access start: lanes match mask, turnaround gap after a read
      if (!mem_ce_n && p_ce) begin
        logic [1:0] m;
        m = (mask_q.size() != 0) ? mask_q.pop_front() : 2'b00;
        check(mem_be_n === ~m, "R3 lane enables", mem_be_n, ~m);
        if (gap_on) check(gap_cnt >= N_TURN + 1, "R8 read turnaround gap", gap_cnt, N_TURN + 1);
        gap_on = 1'b0;
      end
      if (!mem_we_n) we_run++;
      else if (!p_we) begin
        check(we_run == N_WP, "R3 write pulse length", we_run, N_WP);
        we_run = 0;
      end
      if (mem_we_n && mem_dq_oe) hold_run++;
      else if (!mem_dq_oe && p_dqoe) begin
        check(hold_run == N_WH, "R4 write hold length", hold_run, N_WH);
        hold_run = 0;
      end
      if (!mem_oe_n) oe_run++;
      else if (!p_oe) begin
        check(oe_run == N_RD, "R6 read window length", oe_run, N_RD);
        oe_run = 0; gap_on = 1'b1; gap_cnt = 0;
      end
      if (gap_on && mem_ce_n) gap_cnt++;
    end
    p_we = mem_we_n; p_oe = mem_oe_n; p_ce = mem_ce_n; p_dqoe = mem_dq_oe;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(mem_ce_n === 1 && mem_oe_n === 1 && mem_we_n === 1 && mem_be_n === 2'b11 &&
          mem_dq_oe === 0 && req_ready === 1 && rsp_valid === 0, "R1 reset state",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe, req_ready, rsp_valid}, 8'b11111010);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1 && mem_ce_n === 1 && rsp_valid === 0, "R1 after reset",
          {req_ready, mem_ce_n, rsp_valid}, 3'b110);

    issue(1'b1, 15'h0010, 16'h1234, 2'b11);
    issue(1'b0, 15'h0010, 16'h0000, 2'b11);
    issue(1'b1, 15'h7FFF, 16'hBEEF, 2'b11);
    issue(1'b0, 15'h7FFF, 16'h0000, 2'b11);
    issue(1'b1, 15'h0010, 16'hABCD, 2'b01);   // R11 lower only -> 12CD
    issue(1'b0, 15'h0010, 16'h0000, 2'b11);
    issue(1'b1, 15'h0010, 16'h5678, 2'b10);   // R11 upper only -> 56CD
    issue(1'b0, 15'h0010, 16'h0000, 2'b11);
    issue(1'b0, 15'h0010, 16'h0000, 2'b01);   // R7 upper lane zero
    issue(1'b0, 15'h0010, 16'h0000, 2'b10);   // R7 lower lane zero
    issue(1'b1, 15'h0010, 16'hFFFF, 2'b00);   // R9 write noop
    issue(1'b0, 15'h0010, 16'h0000, 2'b11);   // still 56CD
    issue(1'b0, 15'h0123, 16'h0000, 2'b00);   // R9 read noop, rdata unchanged
    issue(1'b1, 15'h0200, 16'h00FF, 2'b11);   // write right after read (R8)
    issue(1'b0, 15'h0200, 16'h0000, 2'b11);

    while (exp_q.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
    // R2: one acknowledge per request
    check(n_acked == n_issued, "R2 ack count", n_acked, n_issued);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule